// File: doc/BRIEF.md
# Operand-Conditioned Eight-Bit ALU

This block is a purely combinational arithmetic and logic unit for two's-complement eight-bit words. It receives two operands and a small set of control bits. One bit selects between a bitwise logic unit and an adder-based arithmetic unit. A two-bit code then selects one of four operations inside the chosen unit. The block has no clock and holds no state.

Two conditioning controls act on the operands before the operation runs. The first control exchanges the two operands. The second control then forces the operand that is now in the first position to zero. Used with the subtract code, these two controls give reversed subtraction and negation of either operand. No extra datapath is needed for those results. The result is a single word. Any carry or borrow out of the top bit is dropped, and no status flags are produced.

Top module: `alu8_core`

## Requirements
- R1: Subtraction results wrap modulo 2^8, so a negative difference appears in two's complement. For example, 3−15 gives 0xF4 and 0−1 gives 0xFF.
- R2: When unit_sel=0, the op_code values select these logic operations: 2'b00 gives first AND second, 2'b01 gives first OR second, 2'b10 gives first XOR second, and 2'b11 gives the bitwise NOT of first.
- R3: When unit_sel=1, the op_code values select these arithmetic operations: 2'b00 gives first+second, 2'b01 gives first−second, 2'b10 gives first+1, and 2'b11 gives first−1.
- R4: When swap_ops=1, opnd_b is used as the first operand and opnd_a as the second. When swap_ops=0, opnd_a is first and opnd_b is second.
- R5: When zero_first=1, the first operand is replaced by zero. This happens after any swap.
- R6: With the subtract code (unit_sel=1, op_code=2'b01), the controls give three further results: swap_ops=1 alone gives opnd_b−opnd_a, zero_first=1 alone gives 0−opnd_b, and both set give 0−opnd_a.
- R7: Addition discards the carry out of bit 7. For example, 0xFF+0x01 gives 0x00 and 0x7F+0x01 gives 0x80.
- R8: The increment and decrement codes do not depend on the second operand. With the first operand fixed, changing it leaves the result unchanged.
- R9: The result is a pure function of the current inputs. It follows an input change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | Operand that is first when no swap is applied |
| opnd_b | input | 8 | Operand that is second when no swap is applied |
| unit_sel | input | 1 | 0 selects the logic unit, 1 selects the arithmetic unit |
| op_code | input | 2 | Operation code inside the selected unit |
| zero_first | input | 1 | Forces the conditioned first operand to zero |
| swap_ops | input | 1 | Exchanges the operands before zero forcing |
| result | output | 8 | Eight-bit result |

## Verification
The assertions check, whenever an input changes, that the result relates to the conditioned operands in the way the selected operation requires. For example, the result minus the second operand must equal the first for addition, and the result plus one must equal the first for decrement. Some properties are visible only in the bench's scenarios, because they compare one input pattern with another. These are the invariance of increment and decrement under a change of the second operand, and the immediate response with no clock edge. The concrete wrap-around values at the word boundaries are also checked by the bench.

// File: rtl/alu8_pkg.sv
// Package: shared width and operation codes for the eight-bit ALU.
// Assumes the op_code field keeps this encoding in both units.
package alu8_pkg;
    localparam int DATA_W = 8;

    // Codes inside the logic unit.
    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOT = 2'b11
    } logic_op_e;

    // Codes inside the arithmetic unit.
    typedef enum logic [1:0] {
        AR_ADD = 2'b00,
        AR_SUB = 2'b01,
        AR_INC = 2'b10,
        AR_DEC = 2'b11
    } arith_op_e;
endpackage

// File: rtl/alu8_precond.sv
// Module: operand conditioning stage.
// The swap is applied first. Zero forcing then acts on the swapped first
// operand. The stage is combinational and has no state.
module alu8_precond #(
    parameter int WIDTH = alu8_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             swap_ops,
    input  logic             zero_first,
    output logic [WIDTH-1:0] first,
    output logic [WIDTH-1:0] second
);
    logic [WIDTH-1:0] swapped_first;

    // Purpose: exchange the operands, then zero the first one if asked.
    always_comb begin
        swapped_first = swap_ops ? in_b : in_a;
        second        = swap_ops ? in_a : in_b;
        first         = zero_first ? '0 : swapped_first;
    end
endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise logic unit built from one slice per bit.
// Assumes the op_code encoding from alu8_pkg::logic_op_e.
module alu8_logic #(
    parameter int WIDTH = alu8_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] first,
    input  logic [WIDTH-1:0] second,
    input  logic [1:0]       op_code,
    output logic [WIDTH-1:0] out
);
    import alu8_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Purpose: compute one result bit for the selected logic operation.
        always_comb begin
            case (op_code)
                LG_AND:  out[i] = first[i] & second[i];
                LG_OR:   out[i] = first[i] | second[i];
                LG_XOR:  out[i] = first[i] ^ second[i];
                default: out[i] = ~first[i];
            endcase
        end
    end
endmodule

// File: rtl/alu8_arith.sv
// Module: arithmetic unit built on a single shared ripple-carry adder.
// The op_code selects the adder's second input and its carry-in.
// The carry out of the top bit is never formed, so results wrap.
module alu8_arith #(
    parameter int WIDTH = alu8_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] first,
    input  logic [WIDTH-1:0] second,
    input  logic [1:0]       op_code,
    output logic [WIDTH-1:0] out
);
    import alu8_pkg::*;

    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] carry;

    // Purpose: choose the adder's second input and its carry-in.
    always_comb begin
        case (op_code)
            AR_ADD:  begin addend = second;  carry[0] = 1'b0; end
            AR_SUB:  begin addend = ~second; carry[0] = 1'b1; end
            AR_INC:  begin addend = '0;      carry[0] = 1'b1; end
            default: begin addend = '1;      carry[0] = 1'b0; end
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        // Purpose: sum bit of one full-adder stage.
        assign out[i] = first[i] ^ addend[i] ^ carry[i];
        if (i < WIDTH - 1) begin : g_carry
            // Purpose: carry into the next stage (no carry leaves the top stage).
            assign carry[i+1] = (first[i] & addend[i]) |
                                (carry[i] & (first[i] ^ addend[i]));
        end
    end
endmodule

// File: rtl/alu8_core.sv
// Module: top of the operand-conditioned ALU.
// Operands are conditioned first. Both units then compute in parallel,
// and unit_sel picks one of the two results.
// Purely combinational: no clock, no reset, no state.
module alu8_core #(
    parameter int WIDTH = alu8_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             unit_sel,
    input  logic [1:0]       op_code,
    input  logic             zero_first,
    input  logic             swap_ops,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] cond_first;
    logic [WIDTH-1:0] cond_second;
    logic [WIDTH-1:0] logic_out;
    logic [WIDTH-1:0] arith_out;

    alu8_precond #(.WIDTH(WIDTH)) u_pre (
        .in_a       (opnd_a),
        .in_b       (opnd_b),
        .swap_ops   (swap_ops),
        .zero_first (zero_first),
        .first      (cond_first),
        .second     (cond_second)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_lgc (
        .first   (cond_first),
        .second  (cond_second),
        .op_code (op_code),
        .out     (logic_out)
    );

    alu8_arith #(.WIDTH(WIDTH)) u_ari (
        .first   (cond_first),
        .second  (cond_second),
        .op_code (op_code),
        .out     (arith_out)
    );

    // Purpose: pick the result of the selected unit.
    always_comb begin
        result = unit_sel ? arith_out : logic_out;
    end
endmodule

// File: rtl/alu8_core_chk.sv
// Module: checker for alu8_core, attached with a bind statement.
// It rebuilds the conditioned operands from the ports and checks how the
// result relates to them. Checks are skipped while any input is unknown.
module alu8_core_chk #(
    parameter int WIDTH = alu8_pkg::DATA_W
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             unit_sel,
    input logic [1:0]       op_code,
    input logic             zero_first,
    input logic             swap_ops,
    input logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] p, q, r_minus_q, r_plus_q, r_minus_1, r_plus_1;

    // Purpose: reference operands and relational terms from the ports.
    always_comb begin
        p         = swap_ops ? opnd_b : opnd_a;
        q         = swap_ops ? opnd_a : opnd_b;
        if (zero_first) p = '0;
        r_minus_q = result - q;
        r_plus_q  = result + q;
        r_minus_1 = result - ONE;
        r_plus_1  = result + ONE;
    end

    // Purpose: check the result against the selected operation.
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, unit_sel, op_code, zero_first, swap_ops})) begin
            if (!unit_sel) begin
                case (op_code)
                    2'b00: a_r2_and_bits: assert (((result & ~p) | (result & ~q) | (p & q & ~result)) == '0);
                    2'b01: a_r2_or_bits:  assert (((~result & (p | q)) | (result & ~p & ~q)) == '0);
                    2'b10: a_r2_xor_bits: assert ((result ^ q) == p);
                    default: a_r2_not_bits: assert (((result & p) == '0) && ((result | p) == '1));
                endcase
            end else begin
                case (op_code)
                    2'b00: a_r7_add_wraps: assert (r_minus_q == p);
                    2'b01: a_r1_sub_wraps: assert (r_plus_q == p);
                    2'b10: a_r8_inc_first: assert (r_minus_1 == p);
                    default: a_r8_dec_first: assert (r_plus_1 == p);
                endcase
            end
            if (unit_sel && op_code == 2'b01 && zero_first && !swap_ops) begin
                a_r6_neg_second: assert ((result + opnd_b) == '0);
            end
            if (unit_sel && op_code == 2'b01 && zero_first && swap_ops) begin
                a_r6_neg_first: assert ((result + opnd_a) == '0);
            end
            if (!unit_sel && op_code == 2'b11 && zero_first) begin
                a_r5_not_zero: assert (result == '1);
            end
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu8_core.sv
// Bench for alu8_core: a walked vector table, then directed tests.
module tb_alu8_core;
    logic       clk = 1'b0;
    logic [7:0] opnd_a, opnd_b, result;
    logic       unit_sel, zero_first, swap_ops;
    logic [1:0] op_code;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    alu8_core dut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .unit_sel(unit_sel),
        .op_code(op_code), .zero_first(zero_first), .swap_ops(swap_ops),
        .result(result)
    );

    // Vector layout: {req[3:0], a[7:0], b[7:0], u, op[1:0], zx, sw, exp[7:0]}
    localparam int NV = 21;
    localparam logic [32:0] VEC [NV] = '{
        {4'd2, 8'h3C, 8'h0F, 1'b0, 2'b00, 1'b0, 1'b0, 8'h0C}, // R2 and
        {4'd2, 8'h3C, 8'h0F, 1'b0, 2'b01, 1'b0, 1'b0, 8'h3F}, // R2 or
        {4'd2, 8'h3C, 8'h0F, 1'b0, 2'b10, 1'b0, 1'b0, 8'h33}, // R2 xor
        {4'd2, 8'h3C, 8'h0F, 1'b0, 2'b11, 1'b0, 1'b0, 8'hC3}, // R2 not
        {4'd3, 8'h0F, 8'h03, 1'b1, 2'b00, 1'b0, 1'b0, 8'h12}, // R3 add
        {4'd3, 8'h0F, 8'h03, 1'b1, 2'b01, 1'b0, 1'b0, 8'h0C}, // R3 sub
        {4'd3, 8'h0F, 8'h03, 1'b1, 2'b10, 1'b0, 1'b0, 8'h10}, // R3 inc
        {4'd3, 8'h0F, 8'h03, 1'b1, 2'b11, 1'b0, 1'b0, 8'h0E}, // R3 dec
        {4'd1, 8'h03, 8'h0F, 1'b1, 2'b01, 1'b0, 1'b0, 8'hF4}, // R1 3-15
        {4'd1, 8'h00, 8'h01, 1'b1, 2'b01, 1'b0, 1'b0, 8'hFF}, // R1 0-1
        {4'd7, 8'hFF, 8'h01, 1'b1, 2'b00, 1'b0, 1'b0, 8'h00}, // R7 carry lost
        {4'd7, 8'h7F, 8'h01, 1'b1, 2'b00, 1'b0, 1'b0, 8'h80}, // R7 into sign
        {4'd6, 8'h03, 8'h0F, 1'b1, 2'b01, 1'b0, 1'b1, 8'h0C}, // R6 b-a
        {4'd6, 8'h03, 8'h32, 1'b1, 2'b01, 1'b1, 1'b0, 8'hCE}, // R6 0-b
        {4'd6, 8'h05, 8'h09, 1'b1, 2'b01, 1'b1, 1'b1, 8'hFB}, // R6 0-a
        {4'd4, 8'h0F, 8'hF0, 1'b0, 2'b11, 1'b0, 1'b1, 8'h0F}, // R4 not of b
        {4'd4, 8'h10, 8'h20, 1'b1, 2'b10, 1'b0, 1'b1, 8'h21}, // R4 inc of b
        {4'd5, 8'hFF, 8'hFF, 1'b0, 2'b00, 1'b1, 1'b0, 8'h00}, // R5 and zeroed
        {4'd5, 8'hAA, 8'h55, 1'b0, 2'b01, 1'b1, 1'b0, 8'h55}, // R5 or zeroed
        {4'd5, 8'h77, 8'h00, 1'b1, 2'b10, 1'b1, 1'b0, 8'h01}, // R5 inc of zero
        {4'd5, 8'h10, 8'h20, 1'b1, 2'b11, 1'b1, 1'b1, 8'hFF}  // R5 after swap
    };

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic u,
                         input logic [1:0] op, input logic zx, input logic sw);
        opnd_a = a; opnd_b = b; unit_sel = u; op_code = op;
        zero_first = zx; swap_ops = sw;
    endtask

    task automatic check(input string tag, input logic [7:0] exp);
        n_cmp++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s: result=%02h expected=%02h", tag, result, exp);
        end
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] held;
        drive(8'h00, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0);
        @(negedge clk); #1;
        check("R2 idle zeros", 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][28:21], VEC[i][20:13], VEC[i][12], VEC[i][11:10],
                  VEC[i][9], VEC[i][8]);
            #2;
            check($sformatf("R%0d vector %0d", VEC[i][32:29], i), VEC[i][7:0]);
        end

        // R8: increment and decrement unchanged as the second operand varies
        @(negedge clk);
        drive(8'h40, 8'h00, 1'b1, 2'b10, 1'b0, 1'b0); #2;
        check("R8 inc b=00", 8'h41);
        opnd_b = 8'hFF; #2; check("R8 inc b=FF", 8'h41);
        opnd_b = 8'h5A; #2; check("R8 inc b=5A", 8'h41);
        op_code = 2'b11; #2; check("R8 dec b=5A", 8'h3F);
        opnd_b = 8'h01; #2; check("R8 dec b=01", 8'h3F);

        // R9: result follows inputs between clock edges
        @(posedge clk); #2;
        drive(8'h21, 8'h12, 1'b1, 2'b00, 1'b0, 1'b0); #1;
        check("R9 settle 1", 8'h33);
        held = 8'hAA;
        opnd_a = held; unit_sel = 1'b0; op_code = 2'b10; #1;
        check("R9 settle 2", 8'hB8);

        // R1: boundary of the signed range
        drive(8'h80, 8'h01, 1'b1, 2'b01, 1'b0, 1'b0); #1;
        check("R1 min-1", 8'h7F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule